// File: doc/BRIEF.md
# Four-Stage Add Pipeline

This block is a small in-order processor core that understands one operation: add two registers and put the sum back into the second one. Work moves through four stages. The first stage reads the instruction store and advances the program counter. The second reads both operands from the register file. The third adds them. The fourth writes the sum back.

A new instruction enters on every clock cycle. The program sits in an internal read-only store that is filled at elaboration. The core has no hazard detection and no forwarding, so a program must leave at least two other instructions between an instruction that writes a register and one that reads it. The program counter and a combinational debug read port on the register file are the only things visible outside the core.

Top module: `add_pipe_core`

## Requirements
- R1: While `rst` is high and right after it drops, `pc` is 0 and register i (i = 0..14) holds i*100. Every pipeline field that carries a register number holds 15, and the operand and sum fields hold 0. No register changes during the first four cycles after reset.
- R2: `pc` rises by 2 on every clock edge that `rst` is low, and it wraps to 0 after the last instruction. With 16 instructions that is after byte address 30.
- R3: Each instruction takes two bytes. The byte at the even address is an opcode and is ignored. The byte at the odd address holds the source register in bits 7:4 and the destination register in bits 3:0. The store holds these operand bytes for slots 0..15: 0x89, 0xAB, 0xCD, 0x98, 0xFF, 0x12, 0x30, 0xF5, 0x22, 0xEE, 0x4F, and 0xFF for slots 11 to 15.
- R4: An instruction with source s and destination d writes the 64-bit sum of register s and register d into register d. The sum wraps modulo 2^64.
- R5: The instruction fetched in cycle k (when `pc` = 2k) writes at the edge that ends cycle k+3. `dbg_val` shows the old value during cycle k+3 and the new value from cycle k+4. Back-to-back instructions write in back-to-back cycles.
- R6: Register number 15 means "no register". As a source it reads as 0, and on the debug port it also reads as 0.
- R7: An instruction whose destination is 15 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc | output | 5 | Byte address of the instruction being fetched |
| dbg_idx | input | 4 | Register number for the debug read |
| dbg_val | output | 64 | Combinational value of register `dbg_idx` |

## Verification
A write-back into a register and a debug read of that same register can happen in the same cycle. During that cycle the port must still show the old value, and it must show the sum only after the edge. After every edge the bench reads all sixteen registers through the debug port, so each write is seen both in the cycle before it lands and in the cycle after. Those reads are compared against a cycle schedule built from R3 to R5. The run covers two passes through the store, so the wrap of the program counter and the re-execution of the program that follows it fall under the same comparison.

// File: rtl/add_pipe_pkg.sv
`timescale 1ns/1ps
package add_pipe_pkg;
    localparam int unsigned DEF_XLEN     = 64;
    localparam int unsigned DEF_NREG     = 16;
    localparam int unsigned DEF_PROG_LEN = 16;
    localparam logic [7:0]  OP_ADD       = 8'h60;

    // operand byte: source in [7:4], destination in [3:0]
    function automatic logic [7:0] prog_operands(input int unsigned slot);
        case (slot)
            0:       return 8'h89;
            1:       return 8'hAB;
            2:       return 8'hCD;
            3:       return 8'h98;
            4:       return 8'hFF;
            5:       return 8'h12;
            6:       return 8'h30;
            7:       return 8'hF5;
            8:       return 8'h22;
            9:       return 8'hEE;
            10:      return 8'h4F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] rom_byte(input int unsigned addr);
        if (addr % 2 == 1) return prog_operands(addr / 2);
        return OP_ADD;
    endfunction
endpackage

// File: rtl/add_pipe_rom.sv
`timescale 1ns/1ps
module add_pipe_rom #(
    parameter int unsigned PROG_LEN = 16,
    parameter int unsigned IDXW     = 4,
    localparam int unsigned NBYTES  = 2 * PROG_LEN,
    localparam int unsigned PCW     = $clog2(NBYTES)
) (
    input  logic [PCW-1:0]  pc,
    output logic [IDXW-1:0] src_idx,
    output logic [IDXW-1:0] dst_idx
);
    logic [7:0] bytes_w [NBYTES];

    for (genvar a = 0; a < NBYTES; a++) begin : g_fill
        assign bytes_w[a] = add_pipe_pkg::rom_byte(a);
    end

    logic [PCW-1:0] opnd_addr;
    logic [7:0]     opnd_byte;

    assign opnd_addr = {pc[PCW-1:1], 1'b1};
    assign opnd_byte = bytes_w[opnd_addr];
    assign src_idx   = opnd_byte[7:4];
    assign dst_idx   = opnd_byte[3:0];
endmodule

// File: rtl/add_pipe_regfile.sv
`timescale 1ns/1ps
module add_pipe_regfile #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 16,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_a_idx,
    input  logic [IDXW-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_a_val,
    output logic [XLEN-1:0] rd_b_val,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_val,
    input  logic [IDXW-1:0] dbg_idx,
    output logic [XLEN-1:0] dbg_val
);
    localparam int unsigned NPHYS = NREG - 1;

    logic [XLEN-1:0] cells [NREG];

    for (genvar i = 0; i < NPHYS; i++) begin : g_cell
        logic [XLEN-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst)                                  cell_q <= XLEN'(i * 100);
            else if (wr_en && wr_idx == IDXW'(i))     cell_q <= wr_val;
        end
        assign cells[i] = cell_q;
    end
    assign cells[NPHYS] = '0;

    assign rd_a_val = cells[rd_a_idx];
    assign rd_b_val = cells[rd_b_idx];
    assign dbg_val  = cells[dbg_idx];
endmodule

// File: rtl/add_pipe_core.sv
`timescale 1ns/1ps
module add_pipe_core #(
    parameter int unsigned XLEN     = add_pipe_pkg::DEF_XLEN,
    parameter int unsigned NREG     = add_pipe_pkg::DEF_NREG,
    parameter int unsigned PROG_LEN = add_pipe_pkg::DEF_PROG_LEN,
    localparam int unsigned IDXW    = $clog2(NREG),
    localparam int unsigned PCW     = $clog2(2 * PROG_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PCW-1:0]  pc,
    input  logic [IDXW-1:0] dbg_idx,
    output logic [XLEN-1:0] dbg_val
);
    localparam logic [IDXW-1:0] NOREG = IDXW'(NREG - 1);

    typedef struct packed {
        logic [PCW-1:0]  pc;
        logic [IDXW-1:0] fd_src;
        logic [IDXW-1:0] fd_dst;
        logic [IDXW-1:0] de_dst;
        logic [XLEN-1:0] de_va;
        logic [XLEN-1:0] de_vb;
        logic [IDXW-1:0] ew_dst;
        logic [XLEN-1:0] ew_sum;
    } pipe_t;

    localparam pipe_t PIPE_RST = '{
        pc: '0, fd_src: NOREG, fd_dst: NOREG,
        de_dst: NOREG, de_va: '0, de_vb: '0,
        ew_dst: NOREG, ew_sum: '0
    };

    pipe_t           st_d, st_q;
    logic [IDXW-1:0] rom_src, rom_dst;
    logic [XLEN-1:0] rd_a, rd_b;

    // plain aliases for the checker
    logic [IDXW-1:0] fd_src_q, fd_dst_q, de_dst_q, ew_dst_q;
    logic [XLEN-1:0] de_va_q, de_vb_q, ew_sum_q;
    assign fd_src_q = st_q.fd_src;
    assign fd_dst_q = st_q.fd_dst;
    assign de_dst_q = st_q.de_dst;
    assign de_va_q  = st_q.de_va;
    assign de_vb_q  = st_q.de_vb;
    assign ew_dst_q = st_q.ew_dst;
    assign ew_sum_q = st_q.ew_sum;

    add_pipe_rom #(.PROG_LEN(PROG_LEN), .IDXW(IDXW)) u_rom (
        .pc      (st_q.pc),
        .src_idx (rom_src),
        .dst_idx (rom_dst)
    );

    add_pipe_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (st_q.fd_src),
        .rd_b_idx (st_q.fd_dst),
        .rd_a_val (rd_a),
        .rd_b_val (rd_b),
        .wr_en    (st_q.ew_dst != NOREG),
        .wr_idx   (st_q.ew_dst),
        .wr_val   (st_q.ew_sum),
        .dbg_idx  (dbg_idx),
        .dbg_val  (dbg_val)
    );

    always_comb begin
        st_d        = st_q;
        // fetch and PC update
        st_d.pc     = st_q.pc + PCW'(2);
        st_d.fd_src = rom_src;
        st_d.fd_dst = rom_dst;
        // decode: operand read, destination passes through
        st_d.de_dst = st_q.fd_dst;
        st_d.de_va  = rd_a;
        st_d.de_vb  = rd_b;
        // execute
        st_d.ew_dst = st_q.de_dst;
        st_d.ew_sum = st_q.de_va + st_q.de_vb;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PIPE_RST;
        else     st_q <= st_d;
    end

    assign pc = st_q.pc;
endmodule

// File: rtl/add_pipe_core_chk.sv
`timescale 1ns/1ps
module add_pipe_core_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IDXW = 4,
    parameter int unsigned PCW  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic [PCW-1:0]  pc,
    input logic [IDXW-1:0] fd_src_q,
    input logic [IDXW-1:0] fd_dst_q,
    input logic [IDXW-1:0] de_dst_q,
    input logic [XLEN-1:0] de_va_q,
    input logic [XLEN-1:0] de_vb_q,
    input logic [IDXW-1:0] ew_dst_q,
    input logic [XLEN-1:0] ew_sum_q,
    input logic [XLEN-1:0] rd_a
);
    localparam logic [IDXW-1:0] NOREG = '1;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc == '0 && fd_src_q == NOREG && fd_dst_q == NOREG &&
                 de_dst_q == NOREG && ew_dst_q == NOREG));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc == $past(pc) + PCW'(2));

    assert_dst_travels_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (de_dst_q == $past(fd_dst_q) && ew_dst_q == $past(de_dst_q)));

    assert_sum_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ew_sum_q == $past(de_va_q + de_vb_q));

    assert_noreg_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (fd_src_q == NOREG) |-> rd_a == '0);
endmodule

bind add_pipe_core add_pipe_core_chk #(.XLEN(XLEN), .IDXW(IDXW), .PCW(PCW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc),
    .fd_src_q (fd_src_q),
    .fd_dst_q (fd_dst_q),
    .de_dst_q (de_dst_q),
    .de_va_q  (de_va_q),
    .de_vb_q  (de_vb_q),
    .ew_dst_q (ew_dst_q),
    .ew_sum_q (ew_sum_q),
    .rd_a     (rd_a)
);

// File: tb/sim_add_pipe_core.sv
`timescale 1ns/1ps
module sim_add_pipe_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  pc;
    logic [3:0]  dbg_idx = '0;
    logic [63:0] dbg_val;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;
    logic [63:0] model [16];

    always #2.5 clk = ~clk;

    add_pipe_core u0 (.clk(clk), .rst(rst), .pc(pc), .dbg_idx(dbg_idx), .dbg_val(dbg_val));

    // operand bytes of the stored program, per R3
    function automatic logic [7:0] opnd(input int k);
        case (k)
            0: return 8'h89;  1: return 8'hAB;  2: return 8'hCD;  3: return 8'h98;
            4: return 8'hFF;  5: return 8'h12;  6: return 8'h30;  7: return 8'hF5;
            8: return 8'h22;  9: return 8'hEE; 10: return 8'h4F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] rd(input int r);
        return (r == 15) ? 64'd0 : model[r];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check("R2 pc", 64'(pc), 64'((2 * cyc) % 32));
        for (int r = 0; r < 16; r++) begin
            dbg_idx = 4'(r);
            #0.1;
            if (r == 15) check("R6 reg15", dbg_val, 64'd0);
            else         check(tag, dbg_val, model[r]);
        end
    endtask

    // one edge: apply the write-back that lands at this edge (R5), then compare
    task automatic step();
        string tag;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        tag = "R3 R4 R5 reg";
        if (cyc >= 4) begin
            int k;
            int s;
            int d;
            k = (cyc - 4) % 16;
            s = int'(opnd(k) >> 4);
            d = int'(opnd(k) & 8'h0F);
            if (d == 15) tag = "R7 reg";
            else model[d] = rd(s) + rd(d);
        end else begin
            tag = "R1 reg";
        end
        compare_all(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < 15; r++) model[r] = 64'(r * 100);
        model[15] = 64'd0;
        cyc = 0;
        compare_all("R1 reset reg");
        rst = 1'b0;
    endtask

    task automatic t_first_pass();
        for (int n = 0; n < 18; n++) step();
        // spot values named in R4: 800+900, 1000+1100, 1200+1300
        dbg_idx = 4'd9;  #0.1; check("R4 r9",  dbg_val, 64'd1700);
        dbg_idx = 4'd11; #0.1; check("R4 r11", dbg_val, 64'd2100);
        dbg_idx = 4'd13; #0.1; check("R4 r13", dbg_val, 64'd2500);
        dbg_idx = 4'd8;  #0.1; check("R4 r8",  dbg_val, 64'd2500);
        dbg_idx = 4'd4;  #0.1; check("R7 r4",  dbg_val, 64'd400);
    endtask

    task automatic t_second_pass();
        for (int n = 0; n < 22; n++) step();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_pass();
        t_second_pass();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule